// File: doc/BRIEF.md
# Lockable Identification Page Controller

This block holds a 32-byte identification page that is kept apart from the main memory array. The page can be read and written like a small array until a one-time lock instruction is accepted. After that the page is read-only for good, and only a power-on reset clears the lock. The block sits behind an SPI front end. That front end decodes the instruction and passes in a frame-start event, the page offset and a select bit. The select bit is address bit 10 of the frame, and it picks either the lock path or the data path. The front end also passes in each received data byte, each request for the next outgoing byte, the chip-select rising event, and the write-enable and write-disable instructions.

The block tracks the write-enable latch. It stages the incoming page bytes and applies them only when chip select rises. It also decides whether a write or lock frame may go ahead, and it pulses either a programming request or a refusal. Read frames put out either page bytes at an offset that advances with each byte, or a lock-status byte that repeats until the frame ends. The self-timed programming delay belongs to the shared write engine and is not modelled here.

Top module: `idpage_ctl`

## Requirements
- R1: After reset: `locked` is 0, `wel` is 0, `rd_data` is 00h, and every page byte reads FFh.
- R2: A `wren_set` pulse sets `wel`. A `wrdi` pulse clears it. Neither pulse changes the page or the lock.
- R3: A write frame (`cmd_write`=1, `cmd_sel`=0) that receives at least one byte, with `wel`=1 and the page unlocked, commits its bytes at chip-select rise. Bytes land at `cmd_off`, `cmd_off`+1 and so on, wrapping modulo 32 inside the page. In the cycle after the rise, `prog_start` pulses and `wel` reads 0.
- R4: A write frame that ends while `wel`=0 leaves the page unchanged. It raises neither `prog_start` nor `write_refused`.
- R5: A read frame (`cmd_write`=0, `cmd_sel`=0) shows the page byte at `cmd_off` on `rd_data`. Each `rd_byte_req` moves to the next offset. At offset 31 the pointer stays put, so the same byte repeats and the read never crosses the page boundary.
- R6: A status frame (`cmd_write`=0, `cmd_sel`=1) shows 01h on `rd_data` when locked and 00h when unlocked. The same byte repeats for every `rd_byte_req` until chip select rises.
- R7: A lock frame (`cmd_write`=1, `cmd_sel`=1) that receives at least one byte and ends with `wel`=1 on an unlocked page sets `locked`. The cycle after the rise shows `prog_start`=1 and `wel`=0.
- R8: On a locked page, a write or lock frame that has a byte and ends with `wel`=1 pulses `write_refused` instead of `prog_start`. It also clears `wel` and leaves the page unchanged.
- R9: Once set, `locked` stays 1 through any instruction sequence. Only `rst` clears it.
- R10: Outside a read frame, `rd_data` is 00h. This includes the cycles after chip select rises.
- R11: A write or lock frame that ends with no data byte does nothing. The page, `locked` and `wel` are unchanged, and neither pulse is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| cmd_valid | input | 1 | Frame start: decoded page instruction with its address |
| cmd_write | input | 1 | 1 = write opcode, 0 = read opcode |
| cmd_sel | input | 1 | Address bit 10: 1 = lock/status, 0 = page data |
| cmd_off | input | 5 | Starting byte offset within the page |
| wr_byte_valid | input | 1 | A data byte was received |
| wr_byte | input | 8 | Received data byte |
| rd_byte_req | input | 1 | Front end takes the current byte and wants the next |
| cs_rise | input | 1 | Chip select went high; the frame ends |
| wren_set | input | 1 | Write-enable instruction executed |
| wrdi | input | 1 | Write-disable instruction executed |
| rd_data | output | 8 | Byte to shift out |
| wel | output | 1 | Write-enable latch |
| locked | output | 1 | Page lock state |
| prog_start | output | 1 | One-cycle request to start a programming cycle |
| write_refused | output | 1 | One-cycle flag: write or lock refused on a locked page |

## Verification
If the staging mask or the write pointer goes wrong, the next read frame shows a wrong byte at a specific offset on `rd_data` right away. It also shows the error at the offsets next to the wrapped position. A faulty accept decision shows up in the cycle after chip select rises, as a wrong `prog_start`/`write_refused`/`wel` triple. A lock that fails to stick shows as a status byte of 00h in the next status frame. A read pointer that runs past offset 31 shows as a changing byte where a repeated one is expected.

// File: rtl/idpage_pkg.sv
package idpage_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        FR_IDLE    = 3'd0,
        FR_RD_PAGE = 3'd1,
        FR_RD_STAT = 3'd2,
        FR_WR_PAGE = 3'd3,
        FR_WR_LOCK = 3'd4
    } frame_e;

    typedef struct packed {
        logic commit_page;
        logic commit_lock;
        logic refuse;
    } end_act_t;

    function automatic frame_e frame_of(input logic is_write, input logic sel);
        if (is_write) return sel ? FR_WR_LOCK : FR_WR_PAGE;
        return sel ? FR_RD_STAT : FR_RD_PAGE;
    endfunction

    function automatic logic [BYTE_W-1:0] status_byte(input logic lk);
        return {{(BYTE_W-1){1'b0}}, lk};
    endfunction

    function automatic logic is_wr_frame(input frame_e f);
        return (f == FR_WR_PAGE) || (f == FR_WR_LOCK);
    endfunction

endpackage

// File: rtl/idp_frame_ctl.sv
module idp_frame_ctl
    import idpage_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     cmd_valid,
    input  logic     cmd_write,
    input  logic     cmd_sel,
    input  logic     wr_byte_valid,
    input  logic     cs_rise,
    input  logic     wren_set,
    input  logic     wrdi,
    output frame_e   frame,
    output end_act_t act,
    output logic     wel,
    output logic     locked,
    output logic     prog_start,
    output logic     write_refused
);

    logic got_byte_q;

    // Decision taken at the end of a write-class frame
    always_comb begin
        act = '0;
        if (cs_rise && is_wr_frame(frame) && got_byte_q && wel) begin
            if (locked) begin
                act.refuse = 1'b1;
            end else if (frame == FR_WR_PAGE) begin
                act.commit_page = 1'b1;
            end else begin
                act.commit_lock = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            frame      <= FR_IDLE;
            got_byte_q <= 1'b0;
        end else if (cs_rise) begin
            frame      <= FR_IDLE;
            got_byte_q <= 1'b0;
        end else if (cmd_valid) begin
            frame      <= frame_of(cmd_write, cmd_sel);
            got_byte_q <= 1'b0;
        end else if (wr_byte_valid && is_wr_frame(frame)) begin
            got_byte_q <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wel <= 1'b0;
        end else if (act.commit_page || act.commit_lock || act.refuse) begin
            wel <= 1'b0;
        end else if (wren_set) begin
            wel <= 1'b1;
        end else if (wrdi) begin
            wel <= 1'b0;
        end
    end

    // Sticky lock: only power-on reset clears it
    always_ff @(posedge clk) begin
        if (rst) begin
            locked <= 1'b0;
        end else if (act.commit_lock) begin
            locked <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prog_start    <= 1'b0;
            write_refused <= 1'b0;
        end else begin
            prog_start    <= act.commit_page || act.commit_lock;
            write_refused <= act.refuse;
        end
    end

endmodule

// File: rtl/idp_page_store.sv
module idp_page_store
    import idpage_pkg::*;
#(
    parameter int PAGE_BYTES = 32,
    localparam int OFF_W     = $clog2(PAGE_BYTES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_start,
    input  logic              frame_end,
    input  logic [OFF_W-1:0]  base_off,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wr_byte,
    input  logic              commit,
    input  logic [OFF_W-1:0]  rd_off,
    output logic [BYTE_W-1:0] rd_byte
);

    logic [BYTE_W-1:0]     page_rd  [PAGE_BYTES];
    logic [BYTE_W-1:0]     stage_rd [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] mask_q;
    logic [OFF_W-1:0]      wptr_q;

    // Write pointer wraps modulo the page size
    always_ff @(posedge clk) begin
        if (rst) begin
            wptr_q <= '0;
        end else if (frame_start) begin
            wptr_q <= base_off;
        end else if (wr_en) begin
            wptr_q <= wptr_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || frame_start || frame_end) begin
            mask_q <= '0;
        end else if (wr_en) begin
            mask_q[wptr_q] <= 1'b1;
        end
    end

    for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_cell
        logic [BYTE_W-1:0] cell_q;
        logic [BYTE_W-1:0] stage_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                stage_q <= '0;
            end else if (wr_en && !frame_start && !frame_end && wptr_q == OFF_W'(g)) begin
                stage_q <= wr_byte;
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                cell_q <= '1;
            end else if (commit && mask_q[g]) begin
                cell_q <= stage_q;
            end
        end

        assign page_rd[g]  = cell_q;
        assign stage_rd[g] = stage_q;
    end

    assign rd_byte = page_rd[rd_off];

endmodule

// File: rtl/idp_read_path.sv
module idp_read_path
    import idpage_pkg::*;
#(
    parameter int PAGE_BYTES = 32,
    localparam int OFF_W     = $clog2(PAGE_BYTES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [OFF_W-1:0]  base_off,
    input  logic              rd_byte_req,
    input  frame_e            frame,
    input  logic              locked,
    input  logic [BYTE_W-1:0] page_byte,
    output logic [OFF_W-1:0]  rd_ptr,
    output logic [BYTE_W-1:0] rd_data
);

    localparam logic [OFF_W-1:0] LAST_OFF = OFF_W'(PAGE_BYTES - 1);

    // Pointer stops at the last offset: reads never leave the page
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ptr <= '0;
        end else if (load) begin
            rd_ptr <= base_off;
        end else if (rd_byte_req && frame == FR_RD_PAGE && rd_ptr != LAST_OFF) begin
            rd_ptr <= rd_ptr + 1'b1;
        end
    end

    always_comb begin
        unique case (frame)
            FR_RD_PAGE: rd_data = page_byte;
            FR_RD_STAT: rd_data = status_byte(locked);
            default:    rd_data = '0;
        endcase
    end

endmodule

// File: rtl/idpage_ctl.sv
module idpage_ctl
    import idpage_pkg::*;
#(
    parameter int PAGE_BYTES = 32,
    localparam int OFF_W     = $clog2(PAGE_BYTES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic              cmd_write,
    input  logic              cmd_sel,
    input  logic [OFF_W-1:0]  cmd_off,
    input  logic              wr_byte_valid,
    input  logic [BYTE_W-1:0] wr_byte,
    input  logic              rd_byte_req,
    input  logic              cs_rise,
    input  logic              wren_set,
    input  logic              wrdi,
    output logic [BYTE_W-1:0] rd_data,
    output logic              wel,
    output logic              locked,
    output logic              prog_start,
    output logic              write_refused
);

    frame_e            frame;
    end_act_t          act;
    logic [OFF_W-1:0]  rd_ptr;
    logic [BYTE_W-1:0] page_byte;
    logic              store_wr;
    logic              rd_load;

    assign store_wr = wr_byte_valid && (frame == FR_WR_PAGE);
    assign rd_load  = cmd_valid && !cs_rise;

    idp_frame_ctl u_frame (
        .clk           (clk),
        .rst           (rst),
        .cmd_valid     (cmd_valid),
        .cmd_write     (cmd_write),
        .cmd_sel       (cmd_sel),
        .wr_byte_valid (wr_byte_valid),
        .cs_rise       (cs_rise),
        .wren_set      (wren_set),
        .wrdi          (wrdi),
        .frame         (frame),
        .act           (act),
        .wel           (wel),
        .locked        (locked),
        .prog_start    (prog_start),
        .write_refused (write_refused)
    );

    idp_page_store #(.PAGE_BYTES(PAGE_BYTES)) u_store (
        .clk         (clk),
        .rst         (rst),
        .frame_start (rd_load),
        .frame_end   (cs_rise),
        .base_off    (cmd_off),
        .wr_en       (store_wr),
        .wr_byte     (wr_byte),
        .commit      (act.commit_page),
        .rd_off      (rd_ptr),
        .rd_byte     (page_byte)
    );

    idp_read_path #(.PAGE_BYTES(PAGE_BYTES)) u_read (
        .clk         (clk),
        .rst         (rst),
        .load        (rd_load),
        .base_off    (cmd_off),
        .rd_byte_req (rd_byte_req),
        .frame       (frame),
        .locked      (locked),
        .page_byte   (page_byte),
        .rd_ptr      (rd_ptr),
        .rd_data     (rd_data)
    );

endmodule

// File: rtl/idpage_ctl_chk.sv
module idpage_ctl_chk (
    input logic clk,
    input logic rst,
    input logic wel,
    input logic locked,
    input logic prog_start,
    input logic write_refused
);

    AST_PROG_NEEDS_WEL: assert property (@(posedge clk) disable iff (rst)
        prog_start |-> $past(wel)); // R3

    AST_PULSE_CLEARS_WEL: assert property (@(posedge clk) disable iff (rst)
        (prog_start || write_refused) |-> !wel); // R8

    AST_LOCK_RISE_PROGS: assert property (@(posedge clk) disable iff (rst)
        $rose(locked) |-> prog_start); // R7

    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (rst)
        locked |=> locked); // R9

    AST_NO_PROG_LOCKED: assert property (@(posedge clk) disable iff (rst)
        prog_start |-> !$past(locked)); // R8

    AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(prog_start && write_refused)); // R8

endmodule

bind idpage_ctl idpage_ctl_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .wel           (wel),
    .locked        (locked),
    .prog_start    (prog_start),
    .write_refused (write_refused)
);

// File: tb/tb_idpage_ctl.sv
module tb_idpage_ctl;

    localparam int CLK_PERIOD = 10;
    localparam int PAGE = 32;
    localparam int WATCHDOG = 20000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cmd_valid = 0, cmd_write = 0, cmd_sel = 0;
    logic [4:0] cmd_off = 0;
    logic       wr_byte_valid = 0;
    logic [7:0] wr_byte = 0;
    logic       rd_byte_req = 0, cs_rise = 0, wren_set = 0, wrdi = 0;
    logic [7:0] rd_data;
    logic       wel, locked, prog_start, write_refused;

    int errs = 0;
    int checks = 0;
    int cycles = 0;
    bit done = 0;
    logic last_prog, last_ref;

    // behavioural reference state
    int m_page [PAGE];
    int m_stage [PAGE];
    bit m_mask [PAGE];
    int m_kind, m_ptr, m_wptr;
    bit m_any, m_wel, m_locked, m_prog, m_ref;

    idpage_ctl dut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
        .cmd_sel(cmd_sel), .cmd_off(cmd_off), .wr_byte_valid(wr_byte_valid),
        .wr_byte(wr_byte), .rd_byte_req(rd_byte_req), .cs_rise(cs_rise),
        .wren_set(wren_set), .wrdi(wrdi), .rd_data(rd_data), .wel(wel),
        .locked(locked), .prog_start(prog_start), .write_refused(write_refused)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // reference model: kinds 0 idle, 1 page read, 2 status, 3 page write, 4 lock
    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < PAGE; i++) begin
                m_page[i] = 8'hFF; m_mask[i] = 0; m_stage[i] = 0;
            end
            m_kind = 0; m_ptr = 0; m_wptr = 0; m_any = 0;
            m_wel = 0; m_locked = 0; m_prog = 0; m_ref = 0;
        end else begin
            bit clr;
            clr = 0; m_prog = 0; m_ref = 0;
            if (cs_rise) begin
                if ((m_kind == 3 || m_kind == 4) && m_any && m_wel) begin
                    clr = 1;
                    if (m_locked) m_ref = 1;
                    else begin
                        m_prog = 1;
                        if (m_kind == 3) begin
                            for (int i = 0; i < PAGE; i++)
                                if (m_mask[i]) m_page[i] = m_stage[i];
                        end else m_locked = 1;
                    end
                end
                m_kind = 0; m_any = 0;
                for (int i = 0; i < PAGE; i++) m_mask[i] = 0;
            end else if (cmd_valid) begin
                m_kind = cmd_write ? (cmd_sel ? 4 : 3) : (cmd_sel ? 2 : 1);
                m_ptr = cmd_off; m_wptr = cmd_off; m_any = 0;
                for (int i = 0; i < PAGE; i++) m_mask[i] = 0;
            end else begin
                if (wr_byte_valid && m_kind == 3) begin
                    m_stage[m_wptr] = wr_byte; m_mask[m_wptr] = 1;
                    m_wptr = (m_wptr + 1) % PAGE; m_any = 1;
                end
                if (wr_byte_valid && m_kind == 4) m_any = 1;
                if (rd_byte_req && m_kind == 1 && m_ptr < PAGE - 1) m_ptr++;
            end
            if (clr) m_wel = 0;
            else if (wren_set) m_wel = 1;
            else if (wrdi) m_wel = 0;
        end
    end

    // cycle-by-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (!rst && !done) begin
            int exp_rd;
            exp_rd = (m_kind == 1) ? m_page[m_ptr] : (m_kind == 2) ? int'(m_locked) : 0;
            chk("R5 R6 R10 rd_data", rd_data, exp_rd);
            chk("R2 wel", wel, m_wel);
            chk("R7 R9 locked", locked, m_locked);
            chk("R3 prog_start", prog_start, m_prog);
            chk("R8 write_refused", write_refused, m_ref);
        end
    end

    task automatic cyc();
        @(posedge clk); #2;
    endtask
    task automatic do_wren(); wren_set = 1; cyc(); wren_set = 0; endtask
    task automatic do_wrdi(); wrdi = 1; cyc(); wrdi = 0; endtask
    task automatic do_cmd(input logic w, input logic s, input int off);
        cmd_valid = 1; cmd_write = w; cmd_sel = s; cmd_off = 5'(off);
        cyc(); cmd_valid = 0;
    endtask
    task automatic do_byte(input int b);
        wr_byte_valid = 1; wr_byte = 8'(b); cyc(); wr_byte_valid = 0;
    endtask
    task automatic do_req(); rd_byte_req = 1; cyc(); rd_byte_req = 0; endtask
    task automatic do_cs();
        cs_rise = 1; cyc(); cs_rise = 0;
        last_prog = prog_start; last_ref = write_refused;
        cyc();
    endtask

    initial begin
        while (!done) begin
            @(posedge clk);
            cycles++;
            if (cycles > WATCHDOG) begin
                errs++; checks++;
                $display("FAIL watchdog expired");
                done = 1;
                $display("Result: errors=%0d of %0d checks", errs, checks);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) cyc();
        rst = 0;
        cyc();
        chk("R1 rd_data", rd_data, 0);
        chk("R1 wel", wel, 0);
        chk("R1 locked", locked, 0);
        do_cmd(0, 0, 7);
        chk("R1 erased byte", rd_data, 8'hFF);
        do_cs();

        do_wren(); chk("R2 set", wel, 1);
        do_wrdi(); chk("R2 clear", wel, 0);

        // R4: write with latch clear does nothing
        do_cmd(1, 0, 3); do_byte(8'hAA); do_cs();
        chk("R4 prog", last_prog, 0);
        chk("R4 refused", last_ref, 0);
        do_cmd(0, 0, 3); chk("R4 page", rd_data, 8'hFF); do_cs();

        // R3: write with wrap from offset 30
        do_wren(); do_cmd(1, 0, 30);
        do_byte(8'h11); do_byte(8'h22); do_byte(8'h33);
        do_cs();
        chk("R3 prog", last_prog, 1);
        chk("R3 wel", wel, 0);
        do_cmd(0, 0, 30); chk("R5 first", rd_data, 8'h11);
        do_req(); chk("R5 next", rd_data, 8'h22);
        do_req(); chk("R5 hold at end", rd_data, 8'h22);
        do_cs();
        chk("R10 idle", rd_data, 0);
        do_cmd(0, 0, 0); chk("R3 wrapped", rd_data, 8'h33);
        do_req(); chk("R3 untouched", rd_data, 8'hFF);
        do_cs();

        // R11: empty write and lock frames
        do_wren(); do_cmd(1, 0, 9); do_cs();
        chk("R11 prog", last_prog, 0);
        chk("R11 wel", wel, 1);
        do_cmd(1, 1, 0); do_cs();
        chk("R11 lock", locked, 0);
        do_wrdi();

        // R6: status while unlocked
        do_cmd(0, 1, 0); chk("R6 unlocked", rd_data, 0);
        do_req(); chk("R6 repeat", rd_data, 0);
        do_cs();

        // R7: lock without latch ignored, then accepted
        do_cmd(1, 1, 0); do_byte(8'h02); do_cs();
        chk("R7 no wel", locked, 0);
        do_wren(); do_cmd(1, 1, 0); do_byte(8'h02); do_cs();
        chk("R7 locked", locked, 1);
        chk("R7 prog", last_prog, 1);
        chk("R7 wel", wel, 0);

        do_cmd(0, 1, 5); chk("R6 locked", rd_data, 1);
        for (int k = 0; k < 3; k++) begin do_req(); chk("R6 repeat locked", rd_data, 1); end
        do_cs(); chk("R10 after status", rd_data, 0);

        // R8: writes refused once locked
        do_wren(); do_cmd(1, 0, 5); do_byte(8'h55); do_cs();
        chk("R8 refused", last_ref, 1);
        chk("R8 no prog", last_prog, 0);
        chk("R8 wel", wel, 0);
        do_cmd(0, 0, 5); chk("R8 page", rd_data, 8'hFF); do_cs();
        do_wren(); do_cmd(1, 1, 0); do_byte(8'h02); do_cs();
        chk("R8 relock refused", last_ref, 1);

        // R9: lock survives everything but reset
        do_wrdi(); do_wren(); do_wrdi();
        chk("R9 sticky", locked, 1);
        rst = 1; cyc(); cyc(); rst = 0; cyc();
        chk("R9 reset clears", locked, 0);
        do_cmd(0, 1, 0); chk("R9 status after reset", rd_data, 0); do_cs();

        done = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule